// File: doc/BRIEF.md
# Alarm Time Setting Controller

This block keeps the alarm time of a 24-hour digital clock as hours and minutes and raises a buzzer signal while that time equals the running clock time. The running time arrives as four BCD digits from the timekeeping logic. The stored alarm time is held as four BCD digits, so it can be shown on a display without conversion. It can also be compared digit for digit with the running time, with no divide or modulo logic.

The alarm time is edited with three push buttons that are already debounced and synchronous to the system clock. A set button cycles the controller through three modes: idle, hour-adjust and minute-adjust. In the two adjust modes, an increment or a decrement button steps the selected field by one, and the field wraps as 24-hour time requires. Each button acts only on its rising edge, so holding a button down counts as a single press.

Top module: `alarm_set_ctrl`

## Requirements
- R1: While rst_ni is low, the controller is forced asynchronously to idle mode and the stored alarm time to 00:00. All four alarm digit outputs read 0.
- R2: Each rising edge of set_btn_i moves the mode one step: idle to hour-adjust, hour-adjust to minute-adjust, minute-adjust to idle. Holding the button high for several cycles counts as one press.
- R3: In hour-adjust mode, an increment press adds one to the hour in BCD. The units digit carries into the tens digit (09 becomes 10), and 23 wraps to 00.
- R4: In hour-adjust mode, a decrement press subtracts one from the hour in BCD. The tens digit borrows (10 becomes 09), and 00 wraps to 23.
- R5: In minute-adjust mode, an increment press adds one to the minute in BCD, and 59 wraps to 00. The hour is not changed.
- R6: In minute-adjust mode, a decrement press subtracts one from the minute in BCD, and 00 wraps to 59.
- R7: In idle mode, increment and decrement presses leave the stored time unchanged.
- R8: An increment or decrement button held high for several cycles changes the selected field by exactly one.
- R9: If rising edges of increment and decrement fall in the same cycle, the stored time is left unchanged.
- R10: buzz_o is high exactly when alarm_en_i is high and each alarm digit equals the matching current-time digit. Every digit is a 4-bit BCD value, 0 to 9. A press takes effect at the clock edge that samples it. The outputs show the new value after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alarm_en_i | input | 1 | Alarm enable |
| set_btn_i | input | 1 | Mode-step button level |
| inc_btn_i | input | 1 | Increment button level |
| dec_btn_i | input | 1 | Decrement button level |
| now_hr_tens_i | input | 4 | Current time, hour tens digit (BCD) |
| now_hr_ones_i | input | 4 | Current time, hour units digit (BCD) |
| now_min_tens_i | input | 4 | Current time, minute tens digit (BCD) |
| now_min_ones_i | input | 4 | Current time, minute units digit (BCD) |
| alm_hr_tens_o | output | 4 | Alarm hour tens digit (BCD) |
| alm_hr_ones_o | output | 4 | Alarm hour units digit (BCD) |
| alm_min_tens_o | output | 4 | Alarm minute tens digit (BCD) |
| alm_min_ones_o | output | 4 | Alarm minute units digit (BCD) |
| buzz_o | output | 1 | High while the alarm matches and is enabled |

## Verification
The hour field is driven through a full increment lap of 24 presses and a decrement lap that starts at 00. This separates a correct 23/00 wrap from an off-by-one wrap, and a correct units-to-tens carry from binary counting. The minute field gets the same treatment over 60 steps, and checks after each minute step confirm that the hour stays put, which shows that the mode selects the correct field. Held buttons, coincident increment and decrement presses, and presses in idle mode show whether edge detection and the no-change rules hold. The buzzer is tried with all digits matching, with the enable low, and with a single digit mismatched in turn.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_HOUR = 2'd1,
    MODE_MIN  = 2'd2
  } mode_e;
endpackage

// File: rtl/edge_rise.sv
module edge_rise #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] pulse_o
);
  logic [W-1:0] lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else         lvl_q <= lvl_i;
  end

  assign pulse_o = lvl_i & ~lvl_q;

  for (genvar g = 0; g < W; g++) begin : g_chk
    // R2 R8
    single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pulse_o[g] |=> !pulse_o[g]);
  end
endmodule

// File: rtl/mode_fsm.sv
module mode_fsm
  import alarm_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  adv_i,
  output mode_e mode_o
);
  mode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (adv_i) begin
      unique case (mode_q)
        MODE_IDLE: mode_d = MODE_HOUR;
        MODE_HOUR: mode_d = MODE_MIN;
        MODE_MIN:  mode_d = MODE_IDLE;
        default:   mode_d = MODE_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_IDLE;
    else         mode_q <= mode_d;
  end

  assign mode_o = mode_q;

  // R2
  idle_to_hour_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && mode_q == MODE_IDLE) |=> mode_q == MODE_HOUR);
  // R2
  hour_to_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && mode_q == MODE_HOUR) |=> mode_q == MODE_MIN);
  // R2
  min_to_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && mode_q == MODE_MIN) |=> mode_q == MODE_IDLE);
  // R2
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(mode_q));
endmodule

// File: rtl/bcd_field.sv
module bcd_field #(
  parameter int DW      = 4,
  parameter int MAX_VAL = 59
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          up_i,
  input  logic          dn_i,
  output logic [DW-1:0] tens_o,
  output logic [DW-1:0] ones_o
);
  localparam logic [DW-1:0] MaxT = DW'(MAX_VAL / 10);
  localparam logic [DW-1:0] MaxO = DW'(MAX_VAL % 10);
  localparam logic [DW-1:0] Nine = DW'(9);

  logic [DW-1:0] tens_q, ones_q, tens_d, ones_d;
  logic          at_max, at_zero, step_up, step_dn;

  assign at_max  = (tens_q == MaxT) && (ones_q == MaxO);
  assign at_zero = (tens_q == '0) && (ones_q == '0);
  assign step_up = en_i && up_i && !dn_i;
  assign step_dn = en_i && dn_i && !up_i;

  always_comb begin
    tens_d = tens_q;
    ones_d = ones_q;
    if (step_up) begin
      if (at_max) begin
        tens_d = '0;
        ones_d = '0;
      end else if (ones_q == Nine) begin
        ones_d = '0;
        tens_d = tens_q + 1'b1;
      end else begin
        ones_d = ones_q + 1'b1;
      end
    end else if (step_dn) begin
      if (at_zero) begin
        tens_d = MaxT;
        ones_d = MaxO;
      end else if (ones_q == '0) begin
        ones_d = Nine;
        tens_d = tens_q - 1'b1;
      end else begin
        ones_d = ones_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tens_q <= '0;
      ones_q <= '0;
    end else begin
      tens_q <= tens_d;
      ones_q <= ones_d;
    end
  end

  assign tens_o = tens_q;
  assign ones_o = ones_q;

  // R10
  bcd_digit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ones_q <= Nine && tens_q <= MaxT);
  // R3 R5
  wrap_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && up_i && !dn_i && at_max) |=> (tens_q == '0 && ones_q == '0));
  // R4 R6
  wrap_dn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && dn_i && !up_i && at_zero) |=> (tens_q == MaxT && ones_q == MaxO));
  // R7 R9
  no_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i || (up_i == dn_i)) |=> ($stable(tens_q) && $stable(ones_q)));
endmodule

// File: rtl/alarm_set_ctrl.sv
module alarm_set_ctrl
  import alarm_pkg::*;
#(
  parameter int DW      = 4,
  parameter int HR_MAX  = 23,
  parameter int MIN_MAX = 59
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          alarm_en_i,
  input  logic          set_btn_i,
  input  logic          inc_btn_i,
  input  logic          dec_btn_i,
  input  logic [DW-1:0] now_hr_tens_i,
  input  logic [DW-1:0] now_hr_ones_i,
  input  logic [DW-1:0] now_min_tens_i,
  input  logic [DW-1:0] now_min_ones_i,
  output logic [DW-1:0] alm_hr_tens_o,
  output logic [DW-1:0] alm_hr_ones_o,
  output logic [DW-1:0] alm_min_tens_o,
  output logic [DW-1:0] alm_min_ones_o,
  output logic          buzz_o
);
  localparam int NBTN = 3;

  logic [NBTN-1:0] btn_pulse;
  logic            set_p, inc_p, dec_p;
  mode_e           mode;

  edge_rise #(.W(NBTN)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  ({set_btn_i, inc_btn_i, dec_btn_i}),
    .pulse_o(btn_pulse)
  );
  assign {set_p, inc_p, dec_p} = btn_pulse;

  mode_fsm u_fsm (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (set_p),
    .mode_o(mode)
  );

  bcd_field #(.DW(DW), .MAX_VAL(HR_MAX)) u_hour (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (mode == MODE_HOUR),
    .up_i  (inc_p),
    .dn_i  (dec_p),
    .tens_o(alm_hr_tens_o),
    .ones_o(alm_hr_ones_o)
  );

  bcd_field #(.DW(DW), .MAX_VAL(MIN_MAX)) u_min (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (mode == MODE_MIN),
    .up_i  (inc_p),
    .dn_i  (dec_p),
    .tens_o(alm_min_tens_o),
    .ones_o(alm_min_ones_o)
  );

  assign buzz_o = alarm_en_i
                && (alm_hr_tens_o  == now_hr_tens_i)
                && (alm_hr_ones_o  == now_hr_ones_i)
                && (alm_min_tens_o == now_min_tens_i)
                && (alm_min_ones_o == now_min_ones_i);

  // R10
  buzz_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buzz_o |-> (alarm_en_i && alm_hr_tens_o == now_hr_tens_i
                && alm_min_ones_o == now_min_ones_i));
  // R7
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_IDLE) |=> ($stable(alm_hr_tens_o) && $stable(alm_hr_ones_o)
                             && $stable(alm_min_tens_o) && $stable(alm_min_ones_o)));
  // R5
  min_mode_hour_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_MIN) |=> ($stable(alm_hr_tens_o) && $stable(alm_hr_ones_o)));
endmodule

// File: tb/alarm_set_ctrl_tb.sv
module alarm_set_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       alarm_en_i = 1'b0;
  logic       set_btn_i = 1'b0, inc_btn_i = 1'b0, dec_btn_i = 1'b0;
  logic [3:0] now_hr_tens_i = 4'd1, now_hr_ones_i = 4'd2;
  logic [3:0] now_min_tens_i = 4'd3, now_min_ones_i = 4'd4;
  logic [3:0] alm_hr_tens_o, alm_hr_ones_o, alm_min_tens_o, alm_min_ones_o;
  logic       buzz_o;

  int n_run = 0, n_fail = 0;
  int exp_h = 0, exp_m = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  alarm_set_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .alarm_en_i(alarm_en_i),
    .set_btn_i(set_btn_i), .inc_btn_i(inc_btn_i), .dec_btn_i(dec_btn_i),
    .now_hr_tens_i(now_hr_tens_i), .now_hr_ones_i(now_hr_ones_i),
    .now_min_tens_i(now_min_tens_i), .now_min_ones_i(now_min_ones_i),
    .alm_hr_tens_o(alm_hr_tens_o), .alm_hr_ones_o(alm_hr_ones_o),
    .alm_min_tens_o(alm_min_tens_o), .alm_min_ones_o(alm_min_ones_o),
    .buzz_o(buzz_o)
  );

  task automatic check_time(string req);
    int got_h, got_m;
    bit bad;
    got_h = 10 * int'(alm_hr_tens_o) + int'(alm_hr_ones_o);
    got_m = 10 * int'(alm_min_tens_o) + int'(alm_min_ones_o);
    bad = (got_h != exp_h) || (got_m != exp_m) || alm_hr_ones_o > 9 || alm_min_ones_o > 9;
    n_run++;
    if (bad) begin
      n_fail++;
      $display("FAIL %s: time %0h%0h:%0h%0h expected %02d:%02d", req,
               alm_hr_tens_o, alm_hr_ones_o, alm_min_tens_o, alm_min_ones_o, exp_h, exp_m);
    end
  endtask

  task automatic check_buzz(string req, logic exp);
    n_run++;
    if (buzz_o !== exp) begin
      n_fail++;
      $display("FAIL %s: buzz_o %b expected %b", req, buzz_o, exp);
    end
  endtask

  // drive after a falling edge, release after the next; the rising edge between applies it
  task automatic pulse_btn(bit s, bit i, bit d, int hold);
    @(negedge clk);
    set_btn_i = s; inc_btn_i = i; dec_btn_i = d;
    repeat (hold) @(negedge clk);
    set_btn_i = 1'b0; inc_btn_i = 1'b0; dec_btn_i = 1'b0;
  endtask

  task automatic t_reset();
    rst_ni = 1'b0; alarm_en_i = 1'b1;
    #1; exp_h = 0; exp_m = 0;
    check_time("R1 reset");
    check_buzz("R1 reset buzz", 1'b0);
    @(negedge clk); rst_ni = 1'b1;
  endtask

  task automatic t_idle_ignore();
    pulse_btn(0, 1, 0, 1); check_time("R7 idle inc");
    pulse_btn(0, 0, 1, 1); check_time("R7 idle dec");
  endtask

  task automatic t_hour_inc();
    for (int k = 0; k < 24; k++) begin
      pulse_btn(0, 1, 0, 1);
      exp_h = (exp_h + 1) % 24;
      check_time("R3 hour inc");
    end
  endtask

  task automatic t_hour_dec();
    for (int k = 0; k < 16; k++) begin
      pulse_btn(0, 0, 1, 1);
      exp_h = (exp_h + 23) % 24;
      check_time("R4 hour dec");
    end
  endtask

  task automatic t_held(string req, bit up);
    pulse_btn(0, up, !up, 6);
    if (exp_m >= 0 && req == "R8 hour") exp_h = up ? (exp_h + 1) % 24 : (exp_h + 23) % 24;
    else exp_m = up ? (exp_m + 1) % 60 : (exp_m + 59) % 60;
    check_time(req);
  endtask

  task automatic t_both();
    pulse_btn(0, 1, 1, 1); check_time("R9 both");
  endtask

  task automatic t_min_inc();
    for (int k = 0; k < 60; k++) begin
      pulse_btn(0, 1, 0, 1);
      exp_m = (exp_m + 1) % 60;
      check_time("R5 minute inc");
    end
  endtask

  task automatic t_min_dec();
    for (int k = 0; k < 13; k++) begin
      pulse_btn(0, 0, 1, 1);
      exp_m = (exp_m + 59) % 60;
      check_time("R6 minute dec");
    end
  endtask

  task automatic set_now(int h, int m);
    now_hr_tens_i = 4'(h / 10); now_hr_ones_i = 4'(h % 10);
    now_min_tens_i = 4'(m / 10); now_min_ones_i = 4'(m % 10);
    #1;
  endtask

  task automatic t_buzz();
    alarm_en_i = 1'b1; set_now(exp_h, exp_m);
    check_buzz("R10 match", 1'b1);
    alarm_en_i = 1'b0; #1;
    check_buzz("R10 disabled", 1'b0);
    alarm_en_i = 1'b1;
    for (int d = 0; d < 4; d++) begin
      set_now(exp_h, exp_m);
      case (d)
        0: now_hr_tens_i  = now_hr_tens_i ^ 4'd1;
        1: now_hr_ones_i  = now_hr_ones_i ^ 4'd1;
        2: now_min_tens_i = now_min_tens_i ^ 4'd1;
        default: now_min_ones_i = now_min_ones_i ^ 4'd1;
      endcase
      #1;
      check_buzz("R10 one digit off", 1'b0);
    end
    set_now(exp_h, exp_m);
    check_buzz("R10 match again", 1'b1);
  endtask

  initial begin
    t_reset();
    t_idle_ignore();
    pulse_btn(1, 0, 0, 1);              // R2 idle -> hour
    t_hour_inc();
    t_hour_dec();                       // 00 -> 23 ... 08
    t_held("R8 hour", 1'b1);
    t_both();
    pulse_btn(1, 0, 0, 4);              // R2 held set: hour -> minute once
    t_min_inc();
    t_min_dec();                        // 00 -> 59 ... 47
    t_held("R8 minute", 1'b0);
    t_both();
    pulse_btn(1, 0, 0, 1);              // R2 minute -> idle
    pulse_btn(0, 1, 0, 1); check_time("R2 back to idle");
    pulse_btn(1, 0, 0, 1);              // R2 idle -> hour again
    pulse_btn(0, 1, 0, 1); exp_h = (exp_h + 1) % 24; check_time("R2 hour again");
    pulse_btn(1, 0, 0, 1); pulse_btn(1, 0, 0, 1);   // back to idle
    t_buzz();
    @(negedge clk); rst_ni = 1'b0; #1;
    exp_h = 0; exp_m = 0;
    check_time("R1 reset mid run");
    @(negedge clk); rst_ni = 1'b1;
    pulse_btn(0, 1, 0, 1); check_time("R1 idle after reset");
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule